// File: doc/BRIEF.md
# Integer Execute Unit (Add, Logic, Shift, Compare)

This block is the combinational execute stage of a 32-bit load/store integer core. Each cycle it receives one instruction word together with the two source register values already read out by the register file. It decodes the register-register and register-immediate integer operations and returns the value to be written back, the number of the register that receives it, and a write enable. The register file, memory access, branch handling and multiply/divide are done elsewhere.

The supported set covers add and subtract in wrapping form (no overflow trap), the four bitwise logic operations, logical and arithmetic shifts by a constant or by a register-held amount, and signed and unsigned set-on-less-than, plus the immediate forms of add, compare and logic. Arithmetic immediates are always sign-extended, also for the unsigned variants. Logic immediates are always zero-extended. Any encoding outside the set, and any write aimed at register 0, leaves the write enable low.

Top module: `int_exec_unit`

## Requirements
- R1: Fields: opcode = instr[31:26], rs field = instr[25:21], rt field = instr[20:16], rd field = instr[15:11], shamt = instr[10:6], funct = instr[5:0], immediate = instr[15:0]. Opcode 000000 is the register form and writes rd; every immediate form writes rt.
- R2: Register form funct 100000 (add) and 100001 (add unsigned) give rs_val+rt_val mod 2^32; 100010 (sub) and 100011 (sub unsigned) give rs_val-rt_val mod 2^32. No trap on overflow.
- R3: Funct 100100 gives AND, 100101 OR, 100110 XOR, 100111 NOR of rs_val and rt_val.
- R4: Funct 000000 shifts rt_val left by shamt with zero fill; 000010 shifts right with zero fill; 000011 shifts right filling with copies of bit 31.
- R5: Funct 000100 (left), 000110 (right, zero fill) and 000111 (right, sign fill) shift rt_val by rs_val[4:0]; bits 31:5 of rs_val have no effect.
- R6: Funct 101010 writes 1 when rs_val < rt_val as signed, else 0; funct 101011 compares unsigned. Upper 31 result bits are always 0.
- R7: Opcodes 001000 (add imm), 001001 (add imm unsigned), 001010 (set-less imm signed), 001011 (set-less imm unsigned) use the immediate sign-extended to 32 bits; the unsigned compare then compares that extended value unsigned.
- R8: Opcodes 001100 (AND imm), 001101 (OR imm), 001110 (XOR imm) use the immediate zero-extended to 32 bits.
- R9: Any other opcode, any other funct, a constant shift with a nonzero rs field, or a non-constant-shift register op with nonzero shamt is unsupported: write enable 0 and result 0.
- R10: A supported instruction whose destination register number is 0 drives write enable 0; the result and destination outputs still show the computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to execute |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Value to write back |
| dest_o | output | 5 | Destination register number |
| wr_en_o | output | 1 | Write-back enable |

## Verification
The block holds no state, so a fault in decode or in the datapath shows on result_o, dest_o or wr_en_o in the same cycle the instruction word is applied. A wrong immediate extension shows only in the upper sixteen result bits and only when immediate bit 15 is set, so vectors use immediates with that bit set and clear. Shift faults hide at amounts of zero, so amounts of 4, 5 and 31, with rs_val carrying upper bits for the variable forms, are used to expose fill and masking errors.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] result_o,
  output logic [4:0]      dest_o,
  output logic            wr_en_o
);
  localparam int SHW  = $clog2(XLEN);
  localparam int IMMW = 16;

  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ADDIU = 6'b001001;
  localparam logic [5:0] OP_SLTI  = 6'b001010;
  localparam logic [5:0] OP_SLTIU = 6'b001011;
  localparam logic [5:0] OP_ANDI  = 6'b001100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_XORI  = 6'b001110;

  localparam logic [5:0] FN_SLL  = 6'b000000;
  localparam logic [5:0] FN_SRL  = 6'b000010;
  localparam logic [5:0] FN_SRA  = 6'b000011;
  localparam logic [5:0] FN_SLLV = 6'b000100;
  localparam logic [5:0] FN_SRLV = 6'b000110;
  localparam logic [5:0] FN_SRAV = 6'b000111;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_SUBU = 6'b100011;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_NOR  = 6'b100111;
  localparam logic [5:0] FN_SLT  = 6'b101010;
  localparam logic [5:0] FN_SLTU = 6'b101011;

  wire [5:0]      opc   = instr_i[31:26];
  wire [4:0]      f_rs  = instr_i[25:21];
  wire [4:0]      f_rt  = instr_i[20:16];
  wire [4:0]      f_rd  = instr_i[15:11];
  wire [4:0]      f_sh  = instr_i[10:6];
  wire [5:0]      fn    = instr_i[5:0];
  wire [IMMW-1:0] imm   = instr_i[IMMW-1:0];

  wire            is_reg   = (opc == OP_REG);
  wire [XLEN-1:0] imm_sx   = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  wire [XLEN-1:0] imm_zx   = {{(XLEN-IMMW){1'b0}}, imm};
  wire [SHW-1:0]  sh_const = f_sh[SHW-1:0];
  wire [SHW-1:0]  sh_var   = rs_val_i[SHW-1:0];
  wire            fixed_sh = (fn == FN_SLL) || (fn == FN_SRL) || (fn == FN_SRA);

  function automatic logic [XLEN-1:0] flag(input logic b);
    return {{(XLEN-1){1'b0}}, b};
  endfunction

  logic            op_ok;
  logic [XLEN-1:0] res;

  always_comb begin
    op_ok = 1'b1;
    res   = '0;
    if (is_reg) begin
      case (fn)
        FN_SLL:          res = rt_val_i << sh_const;
        FN_SRL:          res = rt_val_i >> sh_const;
        FN_SRA:          res = $unsigned($signed(rt_val_i) >>> sh_const);
        FN_SLLV:         res = rt_val_i << sh_var;
        FN_SRLV:         res = rt_val_i >> sh_var;
        FN_SRAV:         res = $unsigned($signed(rt_val_i) >>> sh_var);
        FN_ADD, FN_ADDU: res = rs_val_i + rt_val_i;
        FN_SUB, FN_SUBU: res = rs_val_i - rt_val_i;
        FN_AND:          res = rs_val_i & rt_val_i;
        FN_OR:           res = rs_val_i | rt_val_i;
        FN_XOR:          res = rs_val_i ^ rt_val_i;
        FN_NOR:          res = ~(rs_val_i | rt_val_i);
        FN_SLT:          res = flag($signed(rs_val_i) < $signed(rt_val_i));
        FN_SLTU:         res = flag(rs_val_i < rt_val_i);
        default:         op_ok = 1'b0;
      endcase
      if (fixed_sh && f_rs != 5'd0) op_ok = 1'b0;
      if (!fixed_sh && f_sh != 5'd0) op_ok = 1'b0;
    end else begin
      case (opc)
        OP_ADDI, OP_ADDIU: res = rs_val_i + imm_sx;
        OP_SLTI:           res = flag($signed(rs_val_i) < $signed(imm_sx));
        OP_SLTIU:          res = flag(rs_val_i < imm_sx);
        OP_ANDI:           res = rs_val_i & imm_zx;
        OP_ORI:            res = rs_val_i | imm_zx;
        OP_XORI:           res = rs_val_i ^ imm_zx;
        default:           op_ok = 1'b0;
      endcase
    end
    if (!op_ok) res = '0;
  end

  assign result_o = res;
  assign dest_o   = is_reg ? f_rd : f_rt;
  assign wr_en_o  = op_ok && (dest_o != 5'd0);

  always_comb begin
    if (!$isunknown({instr_i, rs_val_i, rt_val_i})) begin
      p_no_write_r0_r10: assert (!wr_en_o || dest_o != 5'd0);
      p_unsup_quiet_r9: assert (wr_en_o || result_o == '0 || dest_o == 5'd0);
      if (is_reg && (fn == FN_SLT || fn == FN_SLTU) && f_sh == 5'd0)
        p_slt_bool_r6: assert (result_o[XLEN-1:1] == '0);
      if (opc == OP_ANDI)
        p_andi_upper_r8: assert (result_o[XLEN-1:IMMW] == '0);
      if (is_reg && fn == FN_SRA && f_rs == 5'd0)
        p_sra_fill_r4: assert (result_o[XLEN-1] == rt_val_i[XLEN-1]);
      if (is_reg && fn == FN_SRLV && rs_val_i[SHW-1:0] != '0)
        p_srlv_zero_top_r5: assert (result_o[XLEN-1] == 1'b0);
    end
  end
endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr, rs_v, rt_v, res;
  logic [4:0]  dest;
  logic        we;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int_exec_unit dut_i (
    .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v),
    .result_o(res), .dest_o(dest), .wr_en_o(we)
  );

  function automatic logic [31:0] rfmt(input logic [5:0] fn, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd,
                                       input logic [4:0] sh);
    return {6'b000000, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] ifmt(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; rs_v = a; rt_v = b;
    #2;
  endtask

  task automatic expect_out(input string req, input logic [31:0] r,
                            input logic [4:0] d, input logic w);
    checks++;
    if (res !== r || dest !== d || we !== w) begin
      errors++;
      $display("FAIL %s: got res=%h dest=%0d we=%b, expected res=%h dest=%0d we=%b",
               req, res, dest, we, r, d, w);
    end
  endtask

  task automatic t_reset_state;
    apply(32'h0, 32'h0, 32'h0);
    expect_out("R10 idle word", 32'h0, 5'd0, 1'b0);
  endtask

  task automatic t_fields;
    apply(rfmt(6'b100000, 5'd1, 5'd2, 5'd17, 5'd0), 32'd3, 32'd4);
    expect_out("R1 reg dest", 32'd7, 5'd17, 1'b1);
    apply(ifmt(6'b001000, 5'd1, 5'd9, 16'h0005), 32'd3, 32'hDEAD);
    expect_out("R1 imm dest", 32'd8, 5'd9, 1'b1);
  endtask

  task automatic t_addsub;
    apply(rfmt(6'b100000, 5'd1, 5'd2, 5'd3, 5'd0), 32'h7FFFFFFF, 32'h1);
    expect_out("R2 add wrap", 32'h80000000, 5'd3, 1'b1);
    apply(rfmt(6'b100001, 5'd1, 5'd2, 5'd3, 5'd0), 32'hFFFFFFFF, 32'h2);
    expect_out("R2 addu wrap", 32'h1, 5'd3, 1'b1);
    apply(rfmt(6'b100010, 5'd1, 5'd2, 5'd3, 5'd0), 32'd5, 32'd7);
    expect_out("R2 sub order", 32'hFFFFFFFE, 5'd3, 1'b1);
    apply(rfmt(6'b100011, 5'd1, 5'd2, 5'd3, 5'd0), 32'h80000000, 32'h1);
    expect_out("R2 subu", 32'h7FFFFFFF, 5'd3, 1'b1);
  endtask

  task automatic t_logic;
    apply(rfmt(6'b100100, 5'd1, 5'd2, 5'd4, 5'd0), 32'hF0, 32'h3C);
    expect_out("R3 and", 32'h30, 5'd4, 1'b1);
    apply(rfmt(6'b100101, 5'd1, 5'd2, 5'd4, 5'd0), 32'hF0, 32'h3C);
    expect_out("R3 or", 32'hFC, 5'd4, 1'b1);
    apply(rfmt(6'b100110, 5'd1, 5'd2, 5'd4, 5'd0), 32'hF0, 32'h3C);
    expect_out("R3 xor", 32'hCC, 5'd4, 1'b1);
    apply(rfmt(6'b100111, 5'd1, 5'd2, 5'd4, 5'd0), 32'hF0, 32'h3C);
    expect_out("R3 nor", 32'hFFFFFF03, 5'd4, 1'b1);
    apply(rfmt(6'b100111, 5'd1, 5'd1, 5'd4, 5'd0), 32'hF0, 32'hF0);
    expect_out("R3 nor self", 32'hFFFFFF0F, 5'd4, 1'b1);
  endtask

  task automatic t_fixed_shift;
    apply(rfmt(6'b000000, 5'd0, 5'd2, 5'd5, 5'd31), 32'hFFFF, 32'h3);
    expect_out("R4 sll 31", 32'h80000000, 5'd5, 1'b1);
    apply(rfmt(6'b000010, 5'd0, 5'd2, 5'd5, 5'd4), 32'h0, 32'h80000000);
    expect_out("R4 srl", 32'h08000000, 5'd5, 1'b1);
    apply(rfmt(6'b000011, 5'd0, 5'd2, 5'd5, 5'd4), 32'h0, 32'h80000000);
    expect_out("R4 sra neg", 32'hF8000000, 5'd5, 1'b1);
    apply(rfmt(6'b000011, 5'd0, 5'd2, 5'd5, 5'd4), 32'h0, 32'h70000000);
    expect_out("R4 sra pos", 32'h07000000, 5'd5, 1'b1);
  endtask

  task automatic t_var_shift;
    apply(rfmt(6'b000100, 5'd1, 5'd2, 5'd6, 5'd0), 32'hFFFFFFE5, 32'h1);
    expect_out("R5 sllv masked", 32'h20, 5'd6, 1'b1);
    apply(rfmt(6'b000110, 5'd1, 5'd2, 5'd6, 5'd0), 32'h00000024, 32'hF0000000);
    expect_out("R5 srlv masked", 32'h0F000000, 5'd6, 1'b1);
    apply(rfmt(6'b000111, 5'd1, 5'd2, 5'd6, 5'd0), 32'h00000024, 32'hF0000000);
    expect_out("R5 srav masked", 32'hFF000000, 5'd6, 1'b1);
  endtask

  task automatic t_compare;
    apply(rfmt(6'b101010, 5'd1, 5'd2, 5'd7, 5'd0), 32'hFFFFFFFF, 32'h0);
    expect_out("R6 slt signed", 32'h1, 5'd7, 1'b1);
    apply(rfmt(6'b101011, 5'd1, 5'd2, 5'd7, 5'd0), 32'hFFFFFFFF, 32'h0);
    expect_out("R6 sltu", 32'h0, 5'd7, 1'b1);
    apply(rfmt(6'b101010, 5'd1, 5'd2, 5'd7, 5'd0), 32'hFF, 32'hFF);
    expect_out("R6 slt equal", 32'h0, 5'd7, 1'b1);
  endtask

  task automatic t_arith_imm;
    apply(ifmt(6'b001000, 5'd0, 5'd8, 16'hFFFF), 32'h0, 32'h0);
    expect_out("R7 addi neg", 32'hFFFFFFFF, 5'd8, 1'b1);
    apply(ifmt(6'b001001, 5'd1, 5'd8, 16'hFFFC), 32'd10, 32'h0);
    expect_out("R7 addiu sext", 32'd6, 5'd8, 1'b1);
    apply(ifmt(6'b001010, 5'd1, 5'd8, 16'hFFF9), 32'hFF, 32'h0);
    expect_out("R7 slti", 32'h0, 5'd8, 1'b1);
    apply(ifmt(6'b001011, 5'd1, 5'd8, 16'hFFFF), 32'd5, 32'h0);
    expect_out("R7 sltiu sext", 32'h1, 5'd8, 1'b1);
  endtask

  task automatic t_logic_imm;
    apply(ifmt(6'b001100, 5'd1, 5'd9, 16'h8001), 32'hFFFFFFFF, 32'h0);
    expect_out("R8 andi", 32'h00008001, 5'd9, 1'b1);
    apply(ifmt(6'b001101, 5'd1, 5'd9, 16'hFFFF), 32'h0, 32'h0);
    expect_out("R8 ori", 32'h0000FFFF, 5'd9, 1'b1);
    apply(ifmt(6'b001110, 5'd1, 5'd9, 16'hFFFF), 32'hFFFF0000, 32'h0);
    expect_out("R8 xori", 32'hFFFFFFFF, 5'd9, 1'b1);
  endtask

  task automatic t_unsupported;
    apply(ifmt(6'b000010, 5'd1, 5'd9, 16'h1234), 32'h5, 32'h6);
    expect_out("R9 bad opcode", 32'h0, 5'd9, 1'b0);
    apply(rfmt(6'b011000, 5'd1, 5'd2, 5'd3, 5'd0), 32'h5, 32'h6);
    expect_out("R9 bad funct", 32'h0, 5'd3, 1'b0);
    apply(rfmt(6'b000010, 5'd1, 5'd2, 5'd3, 5'd4), 32'h5, 32'hF0);
    expect_out("R9 shift rs nonzero", 32'h0, 5'd3, 1'b0);
    apply(rfmt(6'b100000, 5'd1, 5'd2, 5'd3, 5'd1), 32'h5, 32'h6);
    expect_out("R9 add shamt nonzero", 32'h0, 5'd3, 1'b0);
  endtask

  task automatic t_dest_zero;
    apply(rfmt(6'b100000, 5'd1, 5'd2, 5'd0, 5'd0), 32'd3, 32'd4);
    expect_out("R10 reg dest0", 32'd7, 5'd0, 1'b0);
    apply(ifmt(6'b001101, 5'd1, 5'd0, 16'h00F0), 32'h0F, 32'h0);
    expect_out("R10 imm dest0", 32'hFF, 5'd0, 1'b0);
  endtask

  initial begin
    instr = '0; rs_v = '0; rt_v = '0;
    t_reset_state();
    t_fields();
    t_addsub();
    t_logic();
    t_fixed_shift();
    t_var_shift();
    t_compare();
    t_arith_imm();
    t_logic_imm();
    t_unsupported();
    t_dest_zero();
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 20000 && !done; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule